// File: doc/BRIEF.md
# Host Start-of-Frame Timer

This block produces the frame timing of a bus host. Each clock counts as one PHY clock. A down-counter holds the time left in the current frame. When it reaches zero it is loaded again from a programmable interval register. In the cycle after that load, the block raises a one-cycle start-of-frame strobe and advances a 14-bit frame number. Software can read the live remaining time, the frame number and the interval register.

Software writes the interval for the current bus speed, counted in PHY clocks. A run input starts the timer and freezes it. A clear request makes the next start-of-frame carry frame number 0. Periodic schedulers use the odd-frame output to send transfers that are restricted to odd frames or to even frames.

Top module: `hft_sof_timer`

## Requirements
- R1: While reset is asserted, and after it is released, the outputs are: remaining time 0, frame number 0, start-of-frame strobe low, odd-frame low, and interval register equal to parameter RST_IVL (default 59999). Reset is asynchronous and takes effect without a clock edge.
- R2: While running, a nonzero remaining time decreases by exactly one on each clock.
- R3: While running, a remaining time of zero is replaced on the next clock by the interval register value. The start-of-frame strobe is high for exactly that one cycle, and at no other time. A frame therefore lasts interval+1 clocks.
- R4: The frame number steps by one with each start-of-frame and goes from 0x3FFF to 0. It changes at no other time.
- R5: An interval write is visible on the readback one clock later. It does not disturb the running count. A reload in the same cycle as the write uses the previous interval.
- R6: After a clear request, the next start-of-frame carries frame number 0. A request in the same cycle as a reload applies to that reload. A request made while stopped is kept until a start-of-frame occurs. The first start-of-frame after reset also carries 0.
- R7: The odd-frame output is always bit 0 of the frame number: 1 means odd, 0 means even.
- R8: While stopped, the remaining time and the frame number hold, and no start-of-frame is produced, even when the remaining time is zero.
- R9: An interval of 0 gives a start-of-frame on every clock while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock; each rising edge is one count |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | 1 runs the timer, 0 freezes it |
| ivl_wr | input | 1 | Write strobe for the interval register |
| ivl_wdata | input | 16 | New interval in PHY clocks |
| frm_clr | input | 1 | Frame-number clear request |
| ivl_q | output | 16 | Interval register readback |
| remain_q | output | 16 | Live remaining time in the current frame |
| frame_q | output | 14 | Current frame number |
| sof_pulse | output | 1 | One-cycle start-of-frame strobe |
| odd_frame | output | 1 | 1 when the current frame number is odd |

## Verification
The table walk runs the timer with a short interval so that whole frames can be checked clock by clock. It then interleaves stops, interval writes and clear requests so that their timing can be told apart:
- a write mid-frame against a write on the reload cycle;
- a clear mid-frame against a clear on the reload cycle;
- a clear while stopped.

A stop placed while the counter sits at zero separates "zero means reload" from "zero and running means reload". A directed run with an interval of 0 reaches the frame-number wrap, and the same run checks that the strobe comes on consecutive clocks. A reset asserted mid-run checks the asynchronous clear and the restored interval.

// File: rtl/hft_pkg.sv
package hft_pkg;
  // Action applied to the remaining-time counter in a cycle
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_DEC  = 2'd1,
    ACT_LOAD = 2'd2
  } tmr_act_e;
endpackage

// File: rtl/hft_ivl_reg.sv
module hft_ivl_reg #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ivl_q
);
  logic [W-1:0] ivl_r, ivl_n;

  always_comb begin
    ivl_n = ivl_r;
    if (wr_en) ivl_n = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ivl_r <= RST_VAL;
    else if (wr_en) ivl_r <= ivl_n;
  end

  assign ivl_q = ivl_r;
endmodule

// File: rtl/hft_remain_ctr.sv
module hft_remain_ctr
  import hft_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_act_e     act,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] remain_q,
  output logic         at_zero
);
  logic [W-1:0] cnt_r, cnt_n;
  logic         cnt_en;

  assign cnt_en = (act != ACT_HOLD);

  always_comb begin
    cnt_n = cnt_r;
    unique case (act)
      ACT_DEC:  cnt_n = cnt_r - 1'b1;
      ACT_LOAD: cnt_n = load_val;
      default:  cnt_n = cnt_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_r <= '0;
    else if (cnt_en) cnt_r <= cnt_n;
  end

  assign remain_q = cnt_r;
  assign at_zero  = (cnt_r == '0);
endmodule

// File: rtl/hft_frame_ctr.sv
module hft_frame_ctr #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         clr_req,
  output logic [W-1:0] frame_q,
  output logic         sof_q
);
  localparam logic [W-1:0] FRN_MAX = '1;

  logic [W-1:0] frame_r, frame_n;
  logic         pend_r, pend_n;
  logic         sof_r, sof_n;
  logic         zero_next;

  // A clear already pending, or arriving now, zeroes the number at the next step
  assign zero_next = pend_r | clr_req;

  always_comb begin
    frame_n = frame_r;
    pend_n  = zero_next;
    sof_n   = 1'b0;
    if (step) begin
      sof_n  = 1'b1;
      pend_n = 1'b0;
      if (zero_next || (frame_r == FRN_MAX)) frame_n = '0;
      else frame_n = frame_r + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_r <= '0;
      pend_r  <= 1'b1;
      sof_r   <= 1'b0;
    end else begin
      if (step) frame_r <= frame_n;
      pend_r <= pend_n;
      sof_r  <= sof_n;
    end
  end

  assign frame_q = frame_r;
  assign sof_q   = sof_r;
endmodule

// File: rtl/hft_sof_timer.sv
module hft_sof_timer
  import hft_pkg::*;
#(
  parameter int unsigned IVL_W = 16,
  parameter int unsigned FRN_W = 14,
  parameter logic [IVL_W-1:0] RST_IVL = 16'd59999
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             ivl_wr,
  input  logic [IVL_W-1:0] ivl_wdata,
  input  logic             frm_clr,
  output logic [IVL_W-1:0] ivl_q,
  output logic [IVL_W-1:0] remain_q,
  output logic [FRN_W-1:0] frame_q,
  output logic             sof_pulse,
  output logic             odd_frame
);
  logic     at_zero;
  logic     reload;
  tmr_act_e act;

  assign reload = run_en & at_zero;

  always_comb begin
    if (!run_en)     act = ACT_HOLD;
    else if (at_zero) act = ACT_LOAD;
    else             act = ACT_DEC;
  end

  hft_ivl_reg #(.W(IVL_W), .RST_VAL(RST_IVL)) u_ivl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ivl_wr),
    .wr_data (ivl_wdata),
    .ivl_q   (ivl_q)
  );

  hft_remain_ctr #(.W(IVL_W)) u_rem (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .load_val (ivl_q),
    .remain_q (remain_q),
    .at_zero  (at_zero)
  );

  hft_frame_ctr #(.W(FRN_W)) u_frm (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (reload),
    .clr_req (frm_clr),
    .frame_q (frame_q),
    .sof_q   (sof_pulse)
  );

  assign odd_frame = frame_q[0];
endmodule

// File: rtl/hft_sof_timer_chk.sv
module hft_sof_timer_chk #(
  parameter int unsigned IVL_W = 16,
  parameter int unsigned FRN_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             ivl_wr,
  input logic [IVL_W-1:0] ivl_wdata,
  input logic             frm_clr,
  input logic [IVL_W-1:0] ivl_q,
  input logic [IVL_W-1:0] remain_q,
  input logic [FRN_W-1:0] frame_q,
  input logic             sof_pulse
);
  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && remain_q != '0) |=> remain_q == IVL_W'($past(remain_q) - 1'b1));

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && remain_q == '0) |=> (sof_pulse && remain_q == $past(ivl_q)));

  p_no_stray_sof_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_en && remain_q == '0) |=> !sof_pulse);

  p_frame_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && remain_q == '0) |=>
      (frame_q == '0 || frame_q == FRN_W'($past(frame_q) + 1'b1)));

  p_frame_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_en && remain_q == '0) |=> $stable(frame_q));

  p_ivl_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_wr |=> ivl_q == $past(ivl_wdata));

  p_ivl_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ivl_wr |=> $stable(ivl_q));

  p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && remain_q == '0 && frm_clr) |=> frame_q == '0);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> ($stable(remain_q) && $stable(frame_q) && !sof_pulse));
endmodule

bind hft_sof_timer hft_sof_timer_chk #(.IVL_W(IVL_W), .FRN_W(FRN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_en    (run_en),
  .ivl_wr    (ivl_wr),
  .ivl_wdata (ivl_wdata),
  .frm_clr   (frm_clr),
  .ivl_q     (ivl_q),
  .remain_q  (remain_q),
  .frame_q   (frame_q),
  .sof_pulse (sof_pulse)
);

// File: tb/sim_hft_sof_timer.sv
`timescale 1ns/1ps
module sim_hft_sof_timer;
  logic        clk;
  logic        rst_n;
  logic        run_en;
  logic        ivl_wr;
  logic [15:0] ivl_wdata;
  logic        frm_clr;
  logic [15:0] ivl_q;
  logic [15:0] remain_q;
  logic [13:0] frame_q;
  logic        sof_pulse;
  logic        odd_frame;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  hft_sof_timer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .ivl_wr    (ivl_wr),
    .ivl_wdata (ivl_wdata),
    .frm_clr   (frm_clr),
    .ivl_q     (ivl_q),
    .remain_q  (remain_q),
    .frame_q   (frame_q),
    .sof_pulse (sof_pulse),
    .odd_frame (odd_frame)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic        run;
    logic        wr;
    logic [15:0] wd;
    logic        clr;
    logic [15:0] rem;
    logic [13:0] frm;
    logic        sof;
    logic [15:0] ivl;
  } vec_t;

  // inputs applied for one clock, then outputs expected after that edge
  localparam vec_t TBL [32] = '{
    {1'b0,1'b1,16'd3,1'b0, 16'd0,14'd0,1'b0,16'd3},  // stopped, write 3
    {1'b1,1'b0,16'd0,1'b0, 16'd3,14'd0,1'b1,16'd3},  // first SOF carries 0
    {1'b1,1'b0,16'd0,1'b0, 16'd2,14'd0,1'b0,16'd3},
    {1'b1,1'b0,16'd0,1'b0, 16'd1,14'd0,1'b0,16'd3},
    {1'b1,1'b0,16'd0,1'b0, 16'd0,14'd0,1'b0,16'd3},
    {1'b1,1'b0,16'd0,1'b0, 16'd3,14'd1,1'b1,16'd3},  // period 4
    {1'b1,1'b0,16'd0,1'b0, 16'd2,14'd1,1'b0,16'd3},
    {1'b0,1'b0,16'd0,1'b0, 16'd2,14'd1,1'b0,16'd3},  // stop holds
    {1'b0,1'b0,16'd0,1'b0, 16'd2,14'd1,1'b0,16'd3},
    {1'b1,1'b0,16'd0,1'b0, 16'd1,14'd1,1'b0,16'd3},
    {1'b1,1'b1,16'd5,1'b0, 16'd0,14'd1,1'b0,16'd5},  // mid-frame write
    {1'b1,1'b0,16'd0,1'b0, 16'd5,14'd2,1'b1,16'd5},
    {1'b1,1'b0,16'd0,1'b0, 16'd4,14'd2,1'b0,16'd5},
    {1'b1,1'b0,16'd0,1'b1, 16'd3,14'd2,1'b0,16'd5},  // clear mid-frame
    {1'b1,1'b0,16'd0,1'b0, 16'd2,14'd2,1'b0,16'd5},
    {1'b1,1'b0,16'd0,1'b0, 16'd1,14'd2,1'b0,16'd5},
    {1'b1,1'b0,16'd0,1'b0, 16'd0,14'd2,1'b0,16'd5},
    {1'b1,1'b1,16'd1,1'b0, 16'd5,14'd0,1'b1,16'd1},  // write on reload
    {1'b1,1'b0,16'd0,1'b0, 16'd4,14'd0,1'b0,16'd1},
    {1'b1,1'b0,16'd0,1'b0, 16'd3,14'd0,1'b0,16'd1},
    {1'b1,1'b0,16'd0,1'b0, 16'd2,14'd0,1'b0,16'd1},
    {1'b1,1'b0,16'd0,1'b0, 16'd1,14'd0,1'b0,16'd1},
    {1'b1,1'b0,16'd0,1'b0, 16'd0,14'd0,1'b0,16'd1},
    {1'b1,1'b0,16'd0,1'b0, 16'd1,14'd1,1'b1,16'd1},
    {1'b1,1'b0,16'd0,1'b0, 16'd0,14'd1,1'b0,16'd1},
    {1'b1,1'b0,16'd0,1'b1, 16'd1,14'd0,1'b1,16'd1},  // clear on reload
    {1'b1,1'b0,16'd0,1'b0, 16'd0,14'd0,1'b0,16'd1},
    {1'b0,1'b0,16'd0,1'b1, 16'd0,14'd0,1'b0,16'd1},  // stopped at zero, clear
    {1'b1,1'b0,16'd0,1'b0, 16'd1,14'd0,1'b1,16'd1},  // held clear applied
    {1'b1,1'b0,16'd0,1'b0, 16'd0,14'd0,1'b0,16'd1},
    {1'b0,1'b0,16'd0,1'b0, 16'd0,14'd0,1'b0,16'd1},  // zero but stopped
    {1'b1,1'b0,16'd0,1'b0, 16'd1,14'd1,1'b1,16'd1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [15:0] rem, input logic [13:0] frm,
                           input logic sof, input logic [15:0] ivl);
    chk(req, {remain_q, 2'b00, frame_q, 3'b000, sof_pulse, 3'b000, odd_frame, ivl_q},
             {rem, 2'b00, frm, 3'b000, sof, 3'b000, frm[0], ivl});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; ivl_wr = 1'b0; ivl_wdata = '0; frm_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk_state("R1 during reset", 16'd0, 14'd0, 1'b0, 16'd59999);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1 after release", 16'd0, 14'd0, 1'b0, 16'd59999);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 32; i++) begin
      run_en = TBL[i].run; ivl_wr = TBL[i].wr; ivl_wdata = TBL[i].wd; frm_clr = TBL[i].clr;
      @(negedge clk);
      chk_state($sformatf("R2/R3/R4/R5/R6/R7/R8 row %0d", i),
                TBL[i].rem, TBL[i].frm, TBL[i].sof, TBL[i].ivl);
    end

    // R9: interval 0, with clear while stopped, then run to the wrap (R4)
    run_en = 1'b0; ivl_wr = 1'b1; ivl_wdata = 16'd0; frm_clr = 1'b1;
    @(negedge clk);
    chk_state("R8 stopped write", 16'd1, 14'd1, 1'b0, 16'd0);
    ivl_wr = 1'b0; frm_clr = 1'b0; run_en = 1'b1;
    @(negedge clk);
    chk_state("R2 last decrement", 16'd0, 14'd1, 1'b0, 16'd0);
    for (int k = 0; k < 16384; k++) begin
      @(negedge clk);
      if (k == 0 || k == 1 || k == 2 || k == 8191 || k == 16383)
        chk_state($sformatf("R9 R4 every-clock SOF k=%0d", k), 16'd0, 14'(k), 1'b1, 16'd0);
    end
    @(negedge clk);
    chk_state("R4 wrap 0x3FFF to 0", 16'd0, 14'd0, 1'b1, 16'd0);
    run_en = 1'b0;
    @(negedge clk);
    chk_state("R8 stop after wrap", 16'd0, 14'd0, 1'b0, 16'd0);

    // R1: asynchronous reset mid-run
    ivl_wr = 1'b1; ivl_wdata = 16'd9; run_en = 1'b1;
    repeat (4) @(negedge clk);
    ivl_wr = 1'b0;
    #1 rst_n = 1'b0;
    #0.5;
    chk_state("R1 async reset mid-run", 16'd0, 14'd0, 1'b0, 16'd59999);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R3 R6 first SOF after reset", 16'd59999, 14'd0, 1'b1, 16'd59999);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule